// File: doc/BRIEF.md
# Reset-Time Queue Setup Sequencer

This block sits beside the setup register file of a multi-queue buffer controller. It decides the controller's configuration mode when master reset is released. In the two non-serial modes it also fills the per-queue setup registers itself, one queue per write clock. Three strap inputs select the mode: a default-mode pin, bit 1 of the queue-select bus and an offset-select pin. They are captured once, on the first write-clock edge after the active-low master reset is released. Later changes on them have no effect until the next reset.

Default mode gives every queue of the maximum queue count an equal share of the memory. Parallel mode takes the number of queues from the write address bus at the start of loading and shares the memory equally among that many queues. Serial mode leaves the write port idle, because a separate shifter loads the registers. In the two self-loading modes both flag offsets of every queue are 8 or 128, set by the offset-select strap.

Completion is reported on an active-low chain enable output. Several controllers can be chained by wiring each output to the next device's chain enable input. Each device waits for its own input to go low before loading, so a low output at the end of the chain means every device is set up.

Top module: `qsetup_seq`

## Requirements
- R1: While rst_ni is low, cfg_we_o is 0 and chain_en_no is 1.
- R2: On the first clk_i edge after rst_ni rises, the sequencer captures the mode: dflt_mode_i=0 selects default mode; dflt_mode_i=1 with qsel1_i=0 selects parallel mode; both 1 select serial mode. Strap pin changes after that edge have no effect until the next reset.
- R3: Every entry written carries cfg_ofs_o = 8 if ofs_sel_i was 0 at capture and 128 if it was 1.
- R4: No entry is written while chain_en_ni is high. Loading begins on the first clk_i edge that is later than the capture edge and sees chain_en_ni low, and cfg_we_o is high in the cycle after that edge.
- R5: Default mode writes MAX_Q = 8 entries on consecutive cycles, cfg_idx_o going 0,1,...,7. Each entry has cfg_depth_o = TOTAL_WORDS/8 (512) and cfg_base_o = index*depth.
- R6: Parallel mode writes N = wr_addr_i+1 entries, with wr_addr_i sampled on the edge that starts loading. Indices go 0..N-1 on consecutive cycles, cfg_depth_o = floor(4096/N) and cfg_base_o = index*depth.
- R7: In serial mode cfg_we_o stays 0 and chain_en_no stays 1.
- R8: chain_en_no is 1 while entries are being written. It is 0 from the cycle after the last write for as long as chain_en_ni is 0, and afterwards it follows chain_en_ni.
- R9: After the last entry no further entry is written until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Master reset, active low, asynchronous |
| clk_i | input | 1 | Write clock |
| dflt_mode_i | input | 1 | Default-mode strap, low selects default mode |
| qsel1_i | input | 1 | Queue-select bit 1, strap for parallel mode |
| ofs_sel_i | input | 1 | Offset strap, 0 gives 8, 1 gives 128 |
| chain_en_ni | input | 1 | Chain enable in, active low |
| wr_addr_i | input | 3 | Write address bus, queue count minus one in parallel mode |
| chain_en_no | output | 1 | Chain enable out, active low, marks setup done |
| cfg_we_o | output | 1 | Setup register write strobe |
| cfg_idx_o | output | 3 | Queue index of the entry being written |
| cfg_base_o | output | 13 | First memory word of the queue |
| cfg_depth_o | output | 13 | Queue depth in words |
| cfg_ofs_o | output | 8 | Almost-empty and almost-full offset |

## Verification
A mis-captured strap shows up in the first write cycle. The entry count, depth or offset is wrong there, or in serial mode a write appears where none should. A corrupted index or base accumulator gives a wrong cfg_base_o in the second write cycle, before completion is signalled. A wrong sequencer state shows as chain_en_no falling early or late by at least one cycle against the counted writes, or as writes after completion within the few cycles the bench watches after the last entry.

// File: rtl/qsetup_pkg.sv
package qsetup_pkg;

  typedef enum logic [1:0] {
    MODE_DEFAULT  = 2'd0,
    MODE_PARALLEL = 2'd1,
    MODE_SERIAL   = 2'd2
  } setup_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;

  function automatic setup_mode_e decode_mode(input logic dflt_pin, input logic qsel1_pin);
    if (!dflt_pin)      return MODE_DEFAULT;
    else if (!qsel1_pin) return MODE_PARALLEL;
    else                 return MODE_SERIAL;
  endfunction

endpackage

// File: rtl/qsetup_strap.sv
module qsetup_strap
  import qsetup_pkg::*;
#(
  parameter int OFS_LO = 8,
  parameter int OFS_HI = 128,
  localparam int OW = $clog2(OFS_HI + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dflt_mode_i,
  input  logic          qsel1_i,
  input  logic          ofs_sel_i,
  output setup_mode_e   mode_o,
  output logic [OW-1:0] ofs_o,
  output logic          vld_o
);

  // armed stays set through reset and drops on the first edge after release
  logic        armed_q;
  setup_mode_e mode_q;
  logic [OW-1:0] ofs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b1;
    else         armed_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (armed_q) begin
      mode_q <= decode_mode(dflt_mode_i, qsel1_i);
      ofs_q  <= ofs_sel_i ? OW'(OFS_HI) : OW'(OFS_LO);
    end
  end

  assign mode_o = mode_q;
  assign ofs_o  = ofs_q;
  assign vld_o  = !armed_q;

  AST_STRAP_MODE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> $stable(mode_q)); // R2
  AST_STRAP_OFS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> $stable(ofs_q)); // R3

endmodule

// File: rtl/qsetup_depth_lut.sv
module qsetup_depth_lut #(
  parameter int TOTAL_WORDS = 4096,
  parameter int MAX_Q       = 8,
  localparam int QW = (MAX_Q > 1) ? $clog2(MAX_Q) : 1,
  localparam int DW = $clog2(TOTAL_WORDS + 1)
) (
  input  logic [QW-1:0] cnt_m1_i,
  output logic [DW-1:0] depth_o
);

  logic [DW-1:0] tbl [MAX_Q];

  for (genvar k = 0; k < MAX_Q; k++) begin : g_tbl
    assign tbl[k] = DW'(TOTAL_WORDS / (k + 1));
  end

  assign depth_o = tbl[cnt_m1_i];

endmodule

// File: rtl/qsetup_fsm.sv
module qsetup_fsm
  import qsetup_pkg::*;
#(
  parameter int TOTAL_WORDS = 4096,
  parameter int MAX_Q       = 8,
  localparam int QW = (MAX_Q > 1) ? $clog2(MAX_Q) : 1,
  localparam int DW = $clog2(TOTAL_WORDS + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  setup_mode_e   mode_i,
  input  logic          strap_vld_i,
  input  logic          en_ni,
  input  logic [QW-1:0] req_cnt_m1_i,
  input  logic [DW-1:0] depth_i,
  output logic [QW-1:0] cnt_m1_o,
  output logic          we_o,
  output logic [QW-1:0] idx_o,
  output logic [DW-1:0] base_o,
  output logic          done_o
);

  localparam logic [QW-1:0] LastIdx = QW'(MAX_Q - 1);

  seq_state_e    st_q;
  logic [QW-1:0] idx_q;
  logic [QW-1:0] cnt_m1_q;
  logic [DW-1:0] base_q;
  logic [QW-1:0] req_clamped;
  logic          start;
  logic          last;

  if (MAX_Q == (1 << QW)) begin : g_pow2
    assign req_clamped = req_cnt_m1_i;
  end else begin : g_clamp
    assign req_clamped = (req_cnt_m1_i > LastIdx) ? LastIdx : req_cnt_m1_i;
  end

  assign start = strap_vld_i && !en_ni && (mode_i != MODE_SERIAL);
  assign last  = (idx_q == cnt_m1_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      idx_q    <= '0;
      cnt_m1_q <= '0;
      base_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          st_q     <= ST_LOAD;
          idx_q    <= '0;
          base_q   <= '0;
          cnt_m1_q <= (mode_i == MODE_PARALLEL) ? req_clamped : LastIdx;
        end
        ST_LOAD: begin
          if (last) begin
            st_q <= ST_DONE;
          end else begin
            idx_q  <= idx_q + 1'b1;
            base_q <= base_q + depth_i;
          end
        end
        default: st_q <= st_q;
      endcase
    end
  end

  assign cnt_m1_o = cnt_m1_q;
  assign we_o     = (st_q == ST_LOAD);
  assign idx_o    = idx_q;
  assign base_o   = base_q;
  assign done_o   = (st_q == ST_DONE);

  AST_WAIT_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && en_ni) |=> (st_q == ST_IDLE)); // R4
  AST_SERIAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strap_vld_i && mode_i == MODE_SERIAL) |-> !we_o); // R7
  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !last) |=> (we_o && idx_q == $past(idx_q) + 1'b1)); // R5
  AST_BASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !last) |=> (base_q == $past(base_q) + $past(depth_i))); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(we_o && last)); // R8
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && !we_o)); // R9

endmodule

// File: rtl/qsetup_seq.sv
module qsetup_seq
  import qsetup_pkg::*;
#(
  parameter int TOTAL_WORDS = 4096,
  parameter int MAX_Q       = 8,
  parameter int OFS_LO      = 8,
  parameter int OFS_HI      = 128,
  localparam int QW = (MAX_Q > 1) ? $clog2(MAX_Q) : 1,
  localparam int DW = $clog2(TOTAL_WORDS + 1),
  localparam int OW = $clog2(OFS_HI + 1)
) (
  input  logic          rst_ni,
  input  logic          clk_i,
  input  logic          dflt_mode_i,
  input  logic          qsel1_i,
  input  logic          ofs_sel_i,
  input  logic          chain_en_ni,
  input  logic [QW-1:0] wr_addr_i,
  output logic          chain_en_no,
  output logic          cfg_we_o,
  output logic [QW-1:0] cfg_idx_o,
  output logic [DW-1:0] cfg_base_o,
  output logic [DW-1:0] cfg_depth_o,
  output logic [OW-1:0] cfg_ofs_o
);

  setup_mode_e   mode;
  logic          strap_vld;
  logic [QW-1:0] cnt_m1;
  logic [DW-1:0] depth;
  logic          done;

  qsetup_strap #(
    .OFS_LO(OFS_LO),
    .OFS_HI(OFS_HI)
  ) u_strap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dflt_mode_i(dflt_mode_i),
    .qsel1_i    (qsel1_i),
    .ofs_sel_i  (ofs_sel_i),
    .mode_o     (mode),
    .ofs_o      (cfg_ofs_o),
    .vld_o      (strap_vld)
  );

  qsetup_depth_lut #(
    .TOTAL_WORDS(TOTAL_WORDS),
    .MAX_Q      (MAX_Q)
  ) u_lut (
    .cnt_m1_i(cnt_m1),
    .depth_o (depth)
  );

  qsetup_fsm #(
    .TOTAL_WORDS(TOTAL_WORDS),
    .MAX_Q      (MAX_Q)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .strap_vld_i (strap_vld),
    .en_ni       (chain_en_ni),
    .req_cnt_m1_i(wr_addr_i),
    .depth_i     (depth),
    .cnt_m1_o    (cnt_m1),
    .we_o        (cfg_we_o),
    .idx_o       (cfg_idx_o),
    .base_o      (cfg_base_o),
    .done_o      (done)
  );

  // done passes the chain enable through; before that the output is held inactive
  assign chain_en_no = !(done && !chain_en_ni);
  assign cfg_depth_o = depth;

  AST_BUSY_HOLDS_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_o |-> chain_en_no); // R8
  always_comb begin
    if (!rst_ni) AST_RESET_QUIET: assert (!cfg_we_o && chain_en_no); // R1
  end

endmodule

// File: tb/qsetup_seq_tb.sv
module qsetup_seq_tb;

  localparam int TOTAL = 4096;
  localparam int MAXQ  = 8;

  logic       rst_ni = 1'b0;
  logic       clk_i = 1'b0;
  logic       dflt_mode_i = 1'b0;
  logic       qsel1_i = 1'b0;
  logic       ofs_sel_i = 1'b0;
  logic       chain_en_ni = 1'b1;
  logic [2:0] wr_addr_i = '0;
  logic        chain_en_no;
  logic        cfg_we_o;
  logic [2:0]  cfg_idx_o;
  logic [12:0] cfg_base_o;
  logic [12:0] cfg_depth_o;
  logic [7:0]  cfg_ofs_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  qsetup_seq u_dut (
    .rst_ni(rst_ni), .clk_i(clk_i), .dflt_mode_i(dflt_mode_i), .qsel1_i(qsel1_i),
    .ofs_sel_i(ofs_sel_i), .chain_en_ni(chain_en_ni), .wr_addr_i(wr_addr_i),
    .chain_en_no(chain_en_no), .cfg_we_o(cfg_we_o), .cfg_idx_o(cfg_idx_o),
    .cfg_base_o(cfg_base_o), .cfg_depth_o(cfg_depth_o), .cfg_ofs_o(cfg_ofs_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_cnt(input bit dm, input bit q1, input int addr);
    if (!dm) return MAXQ;
    if (!q1) return addr + 1;
    return 0;
  endfunction

  function automatic int exp_ofs(input bit os);
    return os ? 128 : 8;
  endfunction

  task automatic run_trial(input bit dm, input bit q1, input bit os, input int addr, input int dly);
    int  cnt;
    int  dep;
    int  n;
    bit  ended;
    bit  serial;
    serial = dm && q1;
    cnt = exp_cnt(dm, q1, addr);
    dep = (cnt > 0) ? TOTAL / cnt : 0;
    rst_ni = 1'b0;
    chain_en_ni = 1'b1;
    dflt_mode_i = dm; qsel1_i = q1; ofs_sel_i = os;
    wr_addr_i = 3'($urandom);
    repeat (3) begin
      @(negedge clk_i);
      chk(cfg_we_o == 1'b0, "R1", "we in reset", int'(cfg_we_o), 0);
      chk(chain_en_no == 1'b1, "R1", "chain out in reset", int'(chain_en_no), 1);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    // straps captured on the edge just passed; scramble them now (R2)
    dflt_mode_i = 1'($urandom); qsel1_i = 1'($urandom); ofs_sel_i = 1'($urandom);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk_i);
      chk(cfg_we_o == 1'b0, "R4", "we while chain in high", int'(cfg_we_o), 0);
      chk(chain_en_no == 1'b1, "R4", "chain out while waiting", int'(chain_en_no), 1);
    end
    chain_en_ni = 1'b0;
    wr_addr_i = 3'(addr);
    n = 0;
    ended = 0;
    for (int c = 0; c < MAXQ + 5; c++) begin
      @(negedge clk_i);
      if (cfg_we_o) begin
        if (ended) chk(0, "R9", "write after completion", int'(cfg_idx_o), -1);
        chk(!serial, "R7", "write in serial mode", 1, 0);
        chk(cfg_idx_o == 3'(n), (dm ? "R6" : "R5"), "index", int'(cfg_idx_o), n);
        chk(int'(cfg_depth_o) == dep, (dm ? "R6" : "R5"), "depth", int'(cfg_depth_o), dep);
        chk(int'(cfg_base_o) == n * dep, (dm ? "R6" : "R5"), "base", int'(cfg_base_o), n * dep);
        chk(int'(cfg_ofs_o) == exp_ofs(os), "R3", "offset", int'(cfg_ofs_o), exp_ofs(os));
        chk(chain_en_no == 1'b1, "R8", "chain out during load", int'(chain_en_no), 1);
        n++;
      end else if (!ended) begin
        ended = 1;
        chk(n == cnt, (dm ? "R6" : "R5"), "entry count", n, cnt);
        chk(chain_en_no == serial, (serial ? "R7" : "R8"), "chain out after load",
            int'(chain_en_no), int'(serial));
      end
      if (c == 0) wr_addr_i = 3'($urandom);
    end
    chain_en_ni = 1'b1;
    #1;
    chk(chain_en_no == 1'b1, "R8", "chain out follows high", int'(chain_en_no), 1);
    @(negedge clk_i);
    chain_en_ni = 1'b0;
    #1;
    chk(chain_en_no == serial, "R8", "chain out follows low", int'(chain_en_no), int'(serial));
    @(negedge clk_i);
    chk(cfg_we_o == 1'b0, "R9", "no reload", int'(cfg_we_o), 0);
  endtask

  initial begin
    void'($urandom(32'd5150));
    run_trial(0, 0, 0, 0, 0);  // default, offset 8
    run_trial(0, 1, 1, 5, 2);  // default, offset 128, qsel ignored
    run_trial(1, 0, 0, 0, 1);  // parallel, one queue
    run_trial(1, 0, 1, 7, 0);  // parallel, eight queues
    run_trial(1, 0, 0, 2, 3);  // parallel, three queues, uneven split
    run_trial(1, 1, 1, 4, 1);  // serial
    for (int t = 0; t < 40; t++)
      run_trial(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom_range(0, 7)),
                int'($urandom_range(0, 4)));
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule